// File: doc/BRIEF.md
# Reset-Time Strap Pin Multiplexer

This block shares four processor input pins between two jobs. While the processor is held in reset, and for a short tail after that, the pins carry a clock-multiplier ratio code. Once that window closes, the pins carry four compatibility signals:

- the address-bit-20 mask,
- the ignore-numeric-error request,
- and the two local interrupt lines.

The block folds two supply power-good flags into one power-good output. It generates the active-low processor reset and an active-low CMOS-reset select that steers the pin multiplexer.

After power becomes good and no reset is requested, the processor reset stays asserted for a parameterised number of bus clocks. The default is about one millisecond of a 66 MHz bus clock, so the ratio code meets its setup time. The select then keeps the ratio code on the pins for exactly two more bus clock edges before the compatibility signals take over. A loss of either supply, or a reset request, restarts the whole sequence on the next edge. The ratio code is captured when reset asserts, so later changes at the ratio input cannot disturb the pins. Every output comes from a register clocked by the bus clock.

Top module: `strap_mux_top`

## Requirements
- R1: `pwr_good` equals the AND of `supply_a_ok` and `supply_b_ok`, registered, one clock after the inputs are sampled.
- R2: On any edge where a supply flag is low or `reset_req` is high, `cpu_reset_n` and `cmos_reset_n` both go low at that same edge.
- R3: After the first edge on which both supplies are good and `reset_req` is low, `cpu_reset_n` rises exactly `SETUP_CYCLES` edges later.
- R4: `cmos_reset_n` rises on the second clock edge after the edge on which `cpu_reset_n` rose, and not before.
- R5: `cmos_reset_n` is low in every cycle in which `cpu_reset_n` is low.
- R6: While `cmos_reset_n` is low, `strap_pins` shows the captured ratio code. The code is captured at the synchronous reset and at an edge where `cpu_reset_n` goes from high to low. Changes on `ratio_code` at any other time do not reach the pins.
- R7: While `cmos_reset_n` is high, `strap_pins` shows `compat_in` with one clock of latency, bit for bit. Bit 3 is the address-20 mask, bit 2 is ignore-numeric-error, bit 1 is local interrupt 1 and bit 0 is local interrupt 0.
- R8: A supply loss or reset request during the setup count, the two-edge hold or normal running returns both active-low outputs to low and restarts the setup count from zero.
- R9: While `rst` is high, `pwr_good`, `cpu_reset_n` and `cmos_reset_n` are low, and `strap_pins` takes the value on `ratio_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_a_ok | input | 1 | Good flag of the first supply |
| supply_b_ok | input | 1 | Good flag of the second supply |
| reset_req | input | 1 | Active-high request to reset the processor |
| ratio_code | input | 4 | Clock-multiplier ratio code to present during reset |
| compat_in | input | 4 | Compatibility signals for normal operation (bit 3 down to bit 0: A20 mask, ignore-numeric-error, local int 1, local int 0) |
| pwr_good | output | 1 | Combined power-good, registered |
| cpu_reset_n | output | 1 | Active-low processor reset |
| cmos_reset_n | output | 1 | Active-low pin multiplexer select; low means the ratio code is on the pins |
| strap_pins | output | 4 | Shared processor pins |

## Verification
The hardest case to reach from the ports is a supply drop that lands inside the two-edge hold. That interval lies between reset release and the select release, and lasts only two cycles. A bench cannot steer there by timing stimulus against absolute time. It has to watch `cpu_reset_n` rise and then drop a supply on the very next cycle, and the directed stimulus does exactly that. A second directed case glitches a supply partway through a shortened setup count. Long stretches of seeded random traffic follow, with rare supply drops and reset requests. All of this runs with `SETUP_CYCLES` reduced so that many complete sequences fit in the run.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PIN_COUNT  = 4;
    localparam int HOLD_EDGES = 2;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    typedef enum logic [1:0] {
        SQ_OFF,
        SQ_SETUP,
        SQ_HOLD,
        SQ_RUN
    } seq_state_e;

    typedef struct packed {
        logic cpu_rst_n;
        logic cmos_n;
    } ctl_t;

    function automatic logic supplies_ok(input logic a, input logic b);
        return a & b;
    endfunction

endpackage

// File: rtl/strap_seq.sv
module strap_seq
    import strap_pkg::*;
#(
    parameter int SETUP_CYCLES = 66_667
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_ok,
    input  logic reset_req,
    output ctl_t ctl_q,
    output ctl_t ctl_next,
    output logic capture
);

    localparam int CW = $clog2(SETUP_CYCLES + 2);
    localparam logic [CW-1:0] LAST = CW'(SETUP_CYCLES - 1);
    localparam logic [1:0]    HOLD_LAST = 2'(HOLD_EDGES - 1);

    seq_state_e      st, st_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic [1:0]      hc, hc_n;
    logic            abort;

    assign abort   = !sup_ok || reset_req;
    assign capture = rst || (abort && ctl_q.cpu_rst_n);

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        hc_n     = hc;
        ctl_next = ctl_q;
        if (abort) begin
            st_n     = SQ_OFF;
            cnt_n    = '0;
            hc_n     = '0;
            ctl_next = '0;
        end else begin
            case (st)
                SQ_OFF: begin
                    st_n  = SQ_SETUP;
                    cnt_n = '0;
                end
                SQ_SETUP: begin
                    if (cnt == LAST) begin
                        st_n               = SQ_HOLD;
                        hc_n               = '0;
                        ctl_next.cpu_rst_n = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
                SQ_HOLD: begin
                    if (hc == HOLD_LAST) begin
                        st_n            = SQ_RUN;
                        ctl_next.cmos_n = 1'b1;
                    end else begin
                        hc_n = hc + 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (rst) ctl_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_OFF;
            cnt   <= '0;
            hc    <= '0;
            ctl_q <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            hc    <= hc_n;
            ctl_q <= ctl_next;
        end
    end

    // Checker: cycles with supplies good and reset still held, saturating.
    logic [CW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst || !(sup_ok && !ctl_q.cpu_rst_n) && ctl_q.cpu_rst_n)
            low_run <= '0;
        else if (!ctl_q.cpu_rst_n && !abort && low_run != {CW{1'b1}})
            low_run <= low_run + 1'b1;
        else if (abort)
            low_run <= '0;
    end

    assert_setup_window_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.cpu_rst_n) |-> (low_run >= CW'(SETUP_CYCLES)));

    assert_select_covers_reset_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.cpu_rst_n |-> !ctl_q.cmos_n);

    assert_select_two_edges_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.cmos_n) |-> ($past(ctl_q.cpu_rst_n, 1) && $past(ctl_q.cpu_rst_n, 2)
                                 && !$past(ctl_q.cpu_rst_n, 3)));

    assert_abort_restarts_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!ctl_q.cpu_rst_n && !ctl_q.cmos_n));

endmodule

// File: rtl/strap_pin_mux.sv
module strap_pin_mux
    import strap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  logic     compat_sel_next,
    input  pin_vec_t ratio_in,
    input  pin_vec_t compat_in,
    output pin_vec_t pins_q
);

    pin_vec_t ratio_q;
    pin_vec_t ratio_src;

    assign ratio_src = capture ? ratio_in : ratio_q;

    always_ff @(posedge clk) begin
        if (capture) ratio_q <= ratio_in;
    end

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                pins_q[i] <= ratio_in[i];
            else if (compat_sel_next)
                pins_q[i] <= compat_in[i];
            else
                pins_q[i] <= ratio_src[i];
        end
    end

    assert_compat_follows_R7: assert property (@(posedge clk) disable iff (rst)
        compat_sel_next |=> (pins_q == $past(compat_in)));

endmodule

// File: rtl/strap_mux_top.sv
module strap_mux_top
    import strap_pkg::*;
#(
    parameter int SETUP_CYCLES = 66_667
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_a_ok,
    input  logic       supply_b_ok,
    input  logic       reset_req,
    input  logic [3:0] ratio_code,
    input  logic [3:0] compat_in,
    output logic       pwr_good,
    output logic       cpu_reset_n,
    output logic       cmos_reset_n,
    output logic [3:0] strap_pins
);

    logic pg_q;
    logic sup_ok;
    ctl_t ctl_q, ctl_next;
    logic capture;
    pin_vec_t pins_q;

    assign sup_ok = supplies_ok(supply_a_ok, supply_b_ok);

    always_ff @(posedge clk) begin
        if (rst) pg_q <= 1'b0;
        else     pg_q <= sup_ok;
    end

    strap_seq #(.SETUP_CYCLES(SETUP_CYCLES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sup_ok    (sup_ok),
        .reset_req (reset_req),
        .ctl_q     (ctl_q),
        .ctl_next  (ctl_next),
        .capture   (capture)
    );

    strap_pin_mux u_mux (
        .clk             (clk),
        .rst             (rst),
        .capture         (capture),
        .compat_sel_next (ctl_next.cmos_n),
        .ratio_in        (ratio_code),
        .compat_in       (compat_in),
        .pins_q          (pins_q)
    );

    assign pwr_good     = pg_q;
    assign cpu_reset_n  = ctl_q.cpu_rst_n;
    assign cmos_reset_n = ctl_q.cmos_n;
    assign strap_pins   = pins_q;

    assert_pwr_good_and_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pwr_good == $past(supply_a_ok && supply_b_ok)));

    assert_bad_power_holds_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |-> !cpu_reset_n);

    assert_ratio_steady_R6: assert property (@(posedge clk) disable iff (rst)
        (!cmos_reset_n && !$past(cmos_reset_n) && !$past(cpu_reset_n) && !$past(rst))
            |-> $stable(strap_pins));

endmodule

// File: tb/strap_mux_top_test.sv
`timescale 1ns/1ps
module strap_mux_top_test;

    localparam int S = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_a_ok = 1'b0;
    logic       supply_b_ok = 1'b0;
    logic       reset_req = 1'b0;
    logic [3:0] ratio_code = 4'h0;
    logic [3:0] compat_in = 4'h0;
    logic       pwr_good, cpu_reset_n, cmos_reset_n;
    logic [3:0] strap_pins;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench reference state
    int         m_st = 0;
    int         m_cnt = 0;
    int         m_hc = 0;
    logic       m_rst_n = 0, m_cmos_n = 0, m_pg = 0;
    logic [3:0] m_ratio = 0, m_pins = 0;

    always #2.5 clk = ~clk;

    strap_mux_top #(.SETUP_CYCLES(S)) uut (
        .clk(clk), .rst(rst), .supply_a_ok(supply_a_ok), .supply_b_ok(supply_b_ok),
        .reset_req(reset_req), .ratio_code(ratio_code), .compat_in(compat_in),
        .pwr_good(pwr_good), .cpu_reset_n(cpu_reset_n), .cmos_reset_n(cmos_reset_n),
        .strap_pins(strap_pins)
    );

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Expected behaviour from the requirements, one clock edge at a time.
    function automatic void model_edge();
        logic good, abort;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_hc = 0;
            m_rst_n = 0; m_cmos_n = 0; m_pg = 0; m_ratio = ratio_code;
        end else begin
            good  = supply_a_ok & supply_b_ok;
            abort = !good || reset_req;
            m_pg  = good;
            if (abort) begin
                if (m_rst_n) m_ratio = ratio_code;
                m_st = 0; m_cnt = 0; m_hc = 0; m_rst_n = 0; m_cmos_n = 0;
            end else begin
                case (m_st)
                    0: begin m_st = 1; m_cnt = 0; end
                    1: if (m_cnt == S - 1) begin m_st = 2; m_rst_n = 1; m_hc = 0; end
                       else m_cnt++;
                    2: if (m_hc == 1) begin m_st = 3; m_cmos_n = 1; end
                       else m_hc++;
                    default: ;
                endcase
            end
        end
        m_pins = m_cmos_n ? compat_in : m_ratio;
    endfunction

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R1 pwr_good", pwr_good === m_pg, pwr_good, m_pg);
        check("R3 cpu_reset_n", cpu_reset_n === m_rst_n, cpu_reset_n, m_rst_n);
        check("R4 cmos_reset_n", cmos_reset_n === m_cmos_n, cmos_reset_n, m_cmos_n);
        check(m_cmos_n ? "R7 pins compat" : "R6 pins ratio",
              strap_pins === m_pins, strap_pins, m_pins);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        ratio_code = 4'hA;
        repeat (3) step();
        // R9: reset state
        check("R9 reset outputs", {pwr_good, cpu_reset_n, cmos_reset_n} === 3'b000,
              {pwr_good, cpu_reset_n, cmos_reset_n}, 0);
        check("R9 reset pins", strap_pins === 4'hA, strap_pins, 4'hA);

        rst = 1'b0;
        repeat (4) step();
        supply_a_ok = 1'b1;
        repeat (4) step();
        // R2: one supply alone keeps everything in reset
        check("R2 one supply", {pwr_good, cpu_reset_n, cmos_reset_n} === 3'b000,
              {pwr_good, cpu_reset_n, cmos_reset_n}, 0);

        // R3/R4/R6: full power-up with ratio_code churning
        supply_b_ok = 1'b1;
        n = 0;
        do begin
            ratio_code = 4'($urandom);
            compat_in  = 4'($urandom);
            step();
            n++;
            if (!cpu_reset_n)
                check("R5 select low in reset", cmos_reset_n === 1'b0, cmos_reset_n, 0);
        end while (!cpu_reset_n && n < 4 * S);
        check("R3 release edge count", n == S + 1, n, S + 1);
        check("R6 ratio held", strap_pins === 4'hA, strap_pins, 4'hA);
        step();
        check("R4 still select after 1 edge", cmos_reset_n === 1'b0, cmos_reset_n, 0);
        step();
        check("R4 select released at 2nd edge", cmos_reset_n === 1'b1, cmos_reset_n, 1);
        for (int i = 0; i < 10; i++) begin
            compat_in = 4'($urandom);
            step();
        end

        // R8: reset request during run, new ratio captured
        ratio_code = 4'h5;
        reset_req  = 1'b1;
        step();
        check("R8 request asserts", {cpu_reset_n, cmos_reset_n} === 2'b00,
              {cpu_reset_n, cmos_reset_n}, 0);
        check("R6 captured on assert", strap_pins === 4'h5, strap_pins, 4'h5);
        reset_req = 1'b0;
        ratio_code = 4'h3;
        repeat (S / 2) step();

        // R8: glitch partway through setup
        supply_b_ok = 1'b0;
        step();
        check("R2 glitch in setup", {pwr_good, cpu_reset_n} === 2'b00, {pwr_good, cpu_reset_n}, 0);
        supply_b_ok = 1'b1;
        n = 0;
        do begin step(); n++; end while (!cpu_reset_n && n < 4 * S);
        check("R8 setup restarted", n == S + 1, n, S + 1);
        check("R6 ratio kept after glitch", strap_pins === 4'h5, strap_pins, 4'h5);

        // R8: drop inside the two-edge hold
        ratio_code = 4'hC;
        supply_a_ok = 1'b0;
        step();
        check("R8 drop in hold", {cpu_reset_n, cmos_reset_n} === 2'b00,
              {cpu_reset_n, cmos_reset_n}, 0);
        check("R6 capture in hold", strap_pins === 4'hC, strap_pins, 4'hC);
        supply_a_ok = 1'b1;

        // Random traffic with rare disturbances
        for (int i = 0; i < 3000; i++) begin
            ratio_code  = 4'($urandom);
            compat_in   = 4'($urandom);
            supply_a_ok = ($urandom % 300) != 0;
            supply_b_ok = ($urandom % 300) != 0;
            reset_req   = ($urandom % 400) == 0;
            step();
            if (!cpu_reset_n)
                check("R5 select low in reset", cmos_reset_n === 1'b0, cmos_reset_n, 0);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule